// File: doc/BRIEF.md
# Parallel Bit Gather Unit

This block takes a data word and a selector word. It collects the data bits that sit under set selector bits and packs them, from lowest to highest, into the low end of the result. Every result bit above the packed group is zero. The selected bits do not have to be contiguous, so the operation is neither a shift nor a field slice.

The operand is 32 or 64 bits wide. The width is 64 only when the core reports its 64-bit execution mode and the width-select input is set; in every other case the width is 32. A request whose vector-length field is non-zero is illegal. It produces an invalid-opcode indication instead of a result.

The result and both indications are registered once, so a response appears exactly one clock after the request. The unit has no status-flag outputs.

Top module: `bitgather_unit`

## Requirements
- R1: A request with `in_valid`=1 and `in_len`=0 makes `out_valid`=1 and `out_illegal`=0 on the following clock. Back-to-back requests produce back-to-back results.
- R2: The selector bit set at the k-th lowest position (k counted from 0) places the data bit at that same position in result bit k. The packed bits therefore keep their original relative order.
- R3: Every result bit at position N or above is 0, where N is the number of set selector bits inside the operand width.
- R4: Data bits under cleared selector bits have no effect on the result, and cleared selector bits do not advance the packing position.
- R5: The operand width is 64 bits when `in_mode64`=1 and `in_wide`=1. It is 32 bits for the other three combinations.
- R6: At 32-bit width, bits 63:32 of data and selector are ignored and result bits 63:32 are 0.
- R7: When `in_mode64`=0, `in_wide` has no effect on the result.
- R8: A request with `in_valid`=1 and `in_len`≠0 makes `out_illegal`=1, `out_valid`=0 and `out_result`=0 on the following clock.
- R9: A clock without a request makes `out_valid`=0, `out_illegal`=0 and `out_result`=0 on the following clock.
- R10: While `rst_n`=0 all outputs are 0.
- R11: An all-zero selector gives a zero result. An all-ones selector returns the data truncated to the operand width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_data | input | 64 | Data word |
| in_mask | input | 64 | Selector word |
| in_wide | input | 1 | Width select, 1 requests 64 bits |
| in_mode64 | input | 1 | Core is in 64-bit execution mode |
| in_len | input | 2 | Vector-length field, must be 0 |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Packed result |
| out_illegal | output | 1 | Invalid-opcode indication |

## Verification
The hardest outputs to reach from the ports are those for wide selectors, where a mistake in a high-order packing position moves a single bit near the top of the result. Random words with uniform bits set about half of all selector bits, so they rarely reach such positions. The stimulus therefore also uses all-ones selectors, selectors whose set bits lie only in the upper half, and 32-bit requests that carry random values in the ignored upper halves. It also repeats a request with the unselected data bits inverted, to show that those bits have no influence.

// File: rtl/bx_pkg.sv
package bx_pkg;
    localparam int BX_XLEN   = 64;
    localparam int BX_NARROW = 32;
    localparam int BX_LEN_W  = 2;
    localparam int BX_CNT_W  = $clog2(BX_XLEN + 1);

    typedef struct packed {
        logic               valid;
        logic               illegal;
        logic [BX_XLEN-1:0] result;
    } bx_state_t;
endpackage

// File: rtl/bx_size_ctl.sv
module bx_size_ctl #(
    parameter int XLEN   = 64,
    parameter int NARROW = 32,
    parameter int LEN_W  = 2
) (
    input  logic [XLEN-1:0]  data_i,
    input  logic [XLEN-1:0]  mask_i,
    input  logic             wide_i,
    input  logic             mode64_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             legal_o,
    output logic             is64_o,
    output logic [XLEN-1:0]  data_o,
    output logic [XLEN-1:0]  mask_o
);
    localparam logic [XLEN-1:0] NARROW_KEEP = {{(XLEN-NARROW){1'b0}}, {NARROW{1'b1}}};

    logic [XLEN-1:0] keep;

    always_comb begin
        is64_o  = mode64_i & wide_i;
        legal_o = (len_i == '0);
        keep    = is64_o ? '1 : NARROW_KEEP;
        data_o  = data_i & keep;
        mask_o  = mask_i & keep;
    end
endmodule

// File: rtl/bx_prefix_count.sv
module bx_prefix_count #(
    parameter int XLEN  = 64,
    parameter int CNT_W = 7
) (
    input  logic [XLEN-1:0]             mask_i,
    output logic [XLEN-1:0][CNT_W-1:0]  slot_o,
    output logic [CNT_W-1:0]            total_o
);
    logic [XLEN:0][CNT_W-1:0] run;

    always_comb begin
        run[0] = '0;
        for (int m = 0; m < XLEN; m++) begin
            run[m+1] = run[m] + CNT_W'(mask_i[m]);
        end
        for (int m = 0; m < XLEN; m++) begin
            slot_o[m] = run[m];
        end
        total_o = run[XLEN];
    end
endmodule

// File: rtl/bx_compact.sv
module bx_compact #(
    parameter int XLEN  = 64,
    parameter int CNT_W = 7
) (
    input  logic [XLEN-1:0]            data_i,
    input  logic [XLEN-1:0]            mask_i,
    input  logic [XLEN-1:0][CNT_W-1:0] slot_i,
    output logic [XLEN-1:0]            packed_o
);
    for (genvar k = 0; k < XLEN; k++) begin : g_out
        logic bit_d;
        always_comb begin
            bit_d = 1'b0;
            for (int m = k; m < XLEN; m++) begin
                bit_d = bit_d | (mask_i[m] & data_i[m] & (slot_i[m] == CNT_W'(k)));
            end
        end
        assign packed_o[k] = bit_d;
    end
endmodule

// File: rtl/bitgather_unit.sv
module bitgather_unit
    import bx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [BX_XLEN-1:0]  in_data,
    input  logic [BX_XLEN-1:0]  in_mask,
    input  logic                in_wide,
    input  logic                in_mode64,
    input  logic [BX_LEN_W-1:0] in_len,
    output logic                out_valid,
    output logic [BX_XLEN-1:0]  out_result,
    output logic                out_illegal
);
    logic                             legal;
    logic                             is64;
    logic [BX_XLEN-1:0]               eff_data;
    logic [BX_XLEN-1:0]               eff_mask;
    logic [BX_XLEN-1:0][BX_CNT_W-1:0] slot;
    logic [BX_CNT_W-1:0]              total_cnt;
    logic [BX_XLEN-1:0]               packed_bits;
    bx_state_t                        st_d, st_q;

    bx_size_ctl #(.XLEN(BX_XLEN), .NARROW(BX_NARROW), .LEN_W(BX_LEN_W)) i_size (
        .data_i   (in_data),
        .mask_i   (in_mask),
        .wide_i   (in_wide),
        .mode64_i (in_mode64),
        .len_i    (in_len),
        .legal_o  (legal),
        .is64_o   (is64),
        .data_o   (eff_data),
        .mask_o   (eff_mask)
    );

    bx_prefix_count #(.XLEN(BX_XLEN), .CNT_W(BX_CNT_W)) i_count (
        .mask_i  (eff_mask),
        .slot_o  (slot),
        .total_o (total_cnt)
    );

    bx_compact #(.XLEN(BX_XLEN), .CNT_W(BX_CNT_W)) i_pack (
        .data_i   (eff_data),
        .mask_i   (eff_mask),
        .slot_i   (slot),
        .packed_o (packed_bits)
    );

    always_comb begin
        st_d = '0;
        if (in_valid) begin
            if (legal) begin
                st_d.valid  = 1'b1;
                st_d.result = packed_bits;
            end else begin
                st_d.illegal = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid   = st_q.valid;
    assign out_illegal = st_q.illegal;
    assign out_result  = st_q.result;

    AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_len == '0 |=> out_valid && !out_illegal); // R1
    AST_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_len == '0 |=> (out_result >> $past(total_cnt)) == '0); // R3
    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !(in_mode64 && in_wide) |=> out_result[BX_XLEN-1:BX_NARROW] == '0); // R6
    AST_ILLEGAL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_len != '0 |=> out_illegal && !out_valid && out_result == '0); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !out_illegal && out_result == '0); // R9
    AST_EMPTY_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_len == '0 && in_mask == '0 |=> out_result == '0); // R11
    AST_FULL_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_len == '0 && in_mode64 && in_wide && (&in_mask)
        |=> out_result == $past(in_data)); // R11
    AST_SINGLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_illegal)); // R8
endmodule

// File: tb/test_bitgather_unit.sv
`timescale 1ns/1ps
module test_bitgather_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [63:0] in_data;
    logic [63:0] in_mask;
    logic        in_wide;
    logic        in_mode64;
    logic [1:0]  in_len;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_illegal;

    int checks = 0;
    int errors = 0;
    logic [63:0] last_res;

    always #2.5 clk = ~clk;

    bitgather_unit i_bitgather_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_mask(in_mask), .in_wide(in_wide), .in_mode64(in_mode64), .in_len(in_len),
        .out_valid(out_valid), .out_result(out_result), .out_illegal(out_illegal)
    );

    function automatic logic [63:0] ref_gather(logic [63:0] d, logic [63:0] m, bit w64);
        logic [63:0] r = '0;
        int k = 0;
        int lim = w64 ? 64 : 32;
        for (int i = 0; i < lim; i++) begin
            if (m[i]) begin
                r[k] = d[i];
                k++;
            end
        end
        return r;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic op(bit v, logic [63:0] d, logic [63:0] m, bit w, bit md, logic [1:0] ln, string req);
        logic [63:0] exp_r;
        bit exp_v, exp_i;
        @(negedge clk);
        in_valid = v; in_data = d; in_mask = m; in_wide = w; in_mode64 = md; in_len = ln;
        exp_v = v && (ln == 2'd0);
        exp_i = v && (ln != 2'd0);
        exp_r = exp_v ? ref_gather(d, m, w && md) : 64'd0;
        @(posedge clk);
        #1;
        check({req, " valid"}, {63'd0, out_valid}, {63'd0, exp_v});
        check({req, " illegal"}, {63'd0, out_illegal}, {63'd0, exp_i});
        check({req, " result"}, out_result, exp_r);
        last_res = out_result;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] d, m, r0;
        rst_n = 1'b0; in_valid = 0; in_data = '1; in_mask = '1;
        in_wide = 1; in_mode64 = 1; in_len = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R10 valid", {63'd0, out_valid}, 64'd0);
        check("R10 illegal", {63'd0, out_illegal}, 64'd0);
        check("R10 result", out_result, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        op(0, '1, '1, 1, 1, 0, "R9");
        op(1, '1, '1, 1, 1, 2'd1, "R8");
        op(1, '1, 64'h5, 0, 0, 2'd2, "R8");
        op(1, '1, '1, 1, 1, 2'd3, "R8");
        op(0, 64'h1234, '1, 0, 0, 2'd1, "R9");

        op(1, 64'hDEAD_BEEF_0123_4567, 64'd0, 1, 1, 0, "R11");
        op(1, 64'hDEAD_BEEF_0123_4567, 64'd0, 0, 0, 0, "R11");
        op(1, 64'hDEAD_BEEF_0123_4567, '1, 1, 1, 0, "R11");
        op(1, 64'hDEAD_BEEF_0123_4567, '1, 0, 1, 0, "R11");

        op(1, 64'h0000_0000_0000_00A0, 64'h0000_0000_0000_00F0, 1, 1, 0, "R2");
        op(1, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001, 1, 1, 0, "R2");
        op(1, 64'h9000_0000_0000_0000, 64'hF000_0000_0000_0000, 1, 1, 0, "R2");
        op(1, 64'h1000_0000_0000_0004, 64'h1000_0000_8000_0004, 1, 1, 0, "R3");

        for (int i = 0; i < 60; i++) begin
            op(1, {$urandom, $urandom}, {$urandom, $urandom}, 1, 1, 0, "R5");
        end
        for (int i = 0; i < 40; i++) begin
            op(1, {$urandom, $urandom}, {$urandom, 32'd0}, 1, 1, 0, "R5");
        end
        for (int i = 0; i < 40; i++) begin
            d = {$urandom, $urandom}; m = {$urandom, $urandom};
            op(1, d, m, 0, 1, 0, "R6");
        end
        for (int i = 0; i < 40; i++) begin
            d = {$urandom, $urandom}; m = {$urandom, $urandom};
            op(1, d, m, 1, 0, 0, "R7");
            r0 = last_res;
            op(1, d, m, 0, 0, 0, "R7");
            check("R7 wide ignored", last_res, r0);
        end
        for (int i = 0; i < 40; i++) begin
            d = {$urandom, $urandom}; m = {$urandom, $urandom};
            op(1, d, m, 1, 1, 0, "R4");
            r0 = last_res;
            op(1, d ^ ~m, m, 1, 1, 0, "R4");
            check("R4 unselected data", last_res, r0);
        end
        for (int i = 0; i < 200; i++) begin
            op(($urandom % 4) != 0, {$urandom, $urandom}, {$urandom, $urandom} & {$urandom, $urandom},
               $urandom % 2, $urandom % 2, (($urandom % 6) == 0) ? 2'($urandom % 4) : 2'd0, "R3");
        end
        for (int i = 0; i < 10; i++) begin
            op(1, {$urandom, $urandom}, {$urandom, $urandom}, 1, 1, 0, "R1");
        end
        op(0, '0, '0, 0, 0, 0, "R9");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule